// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits beside a small processor core and decides when the core must leave its current instruction stream to service an interrupt. Nine request lines (external interrupt, pin change, timer overflow, non-volatile memory ready, analog comparator, compare match A, compare match B, watchdog and ADC conversion complete) are each caught in a pending latch. A latched request competes for service only while its own enable bit is set and while the global interrupt-enable flag is set. The request with the lowest vector number wins.

At an instruction boundary the block accepts the winner. On the next cycle it raises a one-cycle strobe that tells the core two things: push the return address, and load the program counter from the presented vector address. On entry it drops the global flag, so handlers do not nest. When the core reports that a return-from-interrupt has executed, the block sets the flag again. A reset request overrides all sources. It presents vector 0 without a push and wipes all pending state.

The core's fetch and execute logic and the stack storage itself are outside this block. A parameter selects one-word or two-word vector spacing.

Top module: `irq_vector_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `vecLoad` and `pcPush` are 0, `gieState` is 0 and no request is pending.
- R2: Source bit i of `irqIn` (0 external, 1 pin change, 2 timer overflow, 3 memory ready, 4 comparator, 5 compare A, 6 compare B, 7 watchdog, 8 ADC done) is serviced at vector number i+1. `vecAddr` equals (i+1) when `WIDE_VEC`=0 and 2*(i+1) when `WIDE_VEC`=1.
- R3: When several enabled requests are pending, the lowest bit index is taken first. The others stay pending and are taken one at a time, in rising index order, after each return.
- R4: An acceptance needs `instrDone`=1, `gieState`=1, no hold-off and an enabled pending request. After the accepting clock edge, `vecLoad` and `pcPush` are both 1 for exactly one cycle, and `gieState` is 0.
- R5: A request whose `srcEnable` bit is 0 is not taken but remains latched. It is taken once its enable bit is set.
- R6: `retiDone` sets `gieState` to 1. In the cycle right after that, no request is accepted, even if one is ready.
- R7: Repeated events on one line before service merge into a single pending request, which is serviced once. Taking a vector clears only that source's latch.
- R8: `rstReq` produces, after the next edge, `vecLoad`=1, `pcPush`=0 and `vecAddr`=0. It clears `gieState` and every pending latch, including events arriving in that same cycle.
- R9: `gieSet` sets and `gieClr` clears `gieState` when neither reset, acceptance nor `retiDone` acts in that cycle.
- R10: No request is accepted while `instrDone` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstReq | input | 1 | Request to jump to the reset vector |
| instrDone | input | 1 | Core is at an instruction boundary |
| retiDone | input | 1 | Core executed a return-from-interrupt |
| gieSet | input | 1 | Core sets the global enable flag |
| gieClr | input | 1 | Core clears the global enable flag |
| irqIn | input | NUM_SRC | Interrupt event lines, bit index = priority order |
| srcEnable | input | NUM_SRC | Per-source enable bits |
| vecLoad | output | 1 | Load program counter from `vecAddr` |
| pcPush | output | 1 | Push the return address before loading |
| vecAddr | output | VEC_W | Vector address to load |
| gieState | output | 1 | Current global interrupt-enable flag |

## Verification
Every ordered pair of sources is raised in the same cycle. The bench then checks that the lower index is served first, that the higher one waits through a hold-off cycle and is served after the return, and that the one-word and two-word spacing variants agree with each other. A source raised alone is served once and does not return, which separates a merged latch from a leaking one. Separate sequences gate the request by its enable bit, by the instruction boundary and by a reset request. These show whether each gate blocks service or only delays it, and whether a reset discards pending work.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // strobes from the sequencing control into the pending/vector datapath
  typedef struct packed {
    logic accept;   // take the current winner this cycle
    logic flush;    // reset vector: drop everything
  } seqStrobe_t;
endpackage

// File: rtl/irq_pend_path.sv
module irq_pend_path
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 9,
  parameter int VEC_W    = 8,
  parameter int WIDE_VEC = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  seqStrobe_t         strobe,
  output logic               anyReady,
  output logic               vecLoad,
  output logic               pcPush,
  output logic [VEC_W-1:0]   vecAddr
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);
  localparam int SHIFT = (WIDE_VEC != 0) ? 1 : 0;

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] readyVec;
  logic [NUM_SRC-1:0] winnerVec;
  logic [IDX_W-1:0]   winNum;
  logic [VEC_W-1:0]   winAddr;

  assign readyVec = pendQ & srcEnable;
  assign anyReady = |readyVec;

  // one pending latch per source; a new event wins over the clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pendQ[g] <= 1'b0;
      else if (strobe.flush)
        pendQ[g] <= 1'b0;
      else
        pendQ[g] <= (pendQ[g] & ~(strobe.accept & winnerVec[g])) | irqIn[g];
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    logic seen;
    seen      = 1'b0;
    winnerVec = '0;
    winNum    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (readyVec[i] && !seen) begin
        winnerVec[i] = 1'b1;
        winNum       = IDX_W'(i + 1);
        seen         = 1'b1;
      end
    end
  end

  assign winAddr = VEC_W'(winNum) << SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecLoad <= 1'b0;
      pcPush  <= 1'b0;
      vecAddr <= '0;
    end else if (strobe.flush) begin
      vecLoad <= 1'b1;
      pcPush  <= 1'b0;
      vecAddr <= '0;
    end else if (strobe.accept) begin
      vecLoad <= 1'b1;
      pcPush  <= 1'b1;
      vecAddr <= winAddr;
    end else begin
      vecLoad <= 1'b0;
      pcPush  <= 1'b0;
    end
  end

  // R3: requests that lost arbitration are still pending afterwards
  a_r3_loser_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && !strobe.flush) |=>
      ((pendQ & $past(readyVec & ~winnerVec)) == $past(readyVec & ~winnerVec)));

  // R8: a reset request leaves nothing pending
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> (pendQ == '0));

  // R1: nothing is pending right after reset release
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pendQ == '0));
endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
  import irq_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rstReq,
  input  logic       instrDone,
  input  logic       retiDone,
  input  logic       gieSet,
  input  logic       gieClr,
  input  logic       anyReady,
  output seqStrobe_t strobe,
  output logic       gieState
);
  logic gieQ;
  logic holdQ;

  assign strobe.flush  = rstReq;
  assign strobe.accept = instrDone & gieQ & ~holdQ & anyReady & ~rstReq;
  assign gieState      = gieQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gieQ <= 1'b0;
    else if (rstReq)         gieQ <= 1'b0;
    else if (strobe.accept)  gieQ <= 1'b0;
    else if (retiDone)       gieQ <= 1'b1;
    else if (gieSet)         gieQ <= 1'b1;
    else if (gieClr)         gieQ <= 1'b0;
  end

  // one-cycle hold-off after a return re-enables interrupts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdQ <= 1'b0;
    else        holdQ <= retiDone & ~rstReq & ~strobe.accept;
  end

  // R4: entry drops the global flag
  a_r4_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accept |=> !gieQ);

  // R6: no acceptance in the cycle after a return
  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (retiDone && !rstReq && !strobe.accept) |=> !strobe.accept);

  // R6: a return re-enables interrupts
  a_r6_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    (retiDone && !rstReq && !strobe.accept) |=> gieQ);

  // R8: reset request clears the global flag
  a_r8_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> !gieQ);
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 9,
  parameter int VEC_W    = 8,
  parameter int WIDE_VEC = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rstReq,
  input  logic               instrDone,
  input  logic               retiDone,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  output logic               vecLoad,
  output logic               pcPush,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               gieState
);
  seqStrobe_t strobe;
  logic       anyReady;

  irq_seq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .rstReq(rstReq), .instrDone(instrDone),
    .retiDone(retiDone), .gieSet(gieSet), .gieClr(gieClr),
    .anyReady(anyReady), .strobe(strobe), .gieState(gieState)
  );

  irq_pend_path #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .WIDE_VEC(WIDE_VEC)) u_path (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .srcEnable(srcEnable),
    .strobe(strobe), .anyReady(anyReady), .vecLoad(vecLoad),
    .pcPush(pcPush), .vecAddr(vecAddr)
  );

  // R4: the push/load strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pcPush |=> !pcPush);

  // R2: an interrupt entry never uses the reset vector
  a_r2_nonzero_vector: assert property (@(posedge clk) disable iff (!rst_n)
    pcPush |-> (vecAddr != '0));

  // R8: a load without a push is always the reset vector
  a_r8_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (vecLoad && !pcPush) |-> (vecAddr == '0));

  // R4: a push always comes with a load and a cleared flag
  a_r4_push_load: assert property (@(posedge clk) disable iff (!rst_n)
    pcPush |-> (vecLoad && !gieState));
endmodule

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rstReq = 0, instrDone = 1, retiDone = 0, gieSet = 0, gieClr = 0;
  logic [N-1:0] irqIn = '0;
  logic [N-1:0] srcEnable = '1;
  logic       vl0, pp0, g0, vl1, pp1, g1;
  logic [7:0] va0, va1;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_vector_ctl #(.NUM_SRC(N), .VEC_W(8), .WIDE_VEC(0)) u_irq_vector_ctl (
    .clk(clk), .rst_n(rst_n), .rstReq(rstReq), .instrDone(instrDone),
    .retiDone(retiDone), .gieSet(gieSet), .gieClr(gieClr), .irqIn(irqIn),
    .srcEnable(srcEnable), .vecLoad(vl0), .pcPush(pp0), .vecAddr(va0),
    .gieState(g0));

  irq_vector_ctl #(.NUM_SRC(N), .VEC_W(8), .WIDE_VEC(1)) u_irq_vector_ctl_wide (
    .clk(clk), .rst_n(rst_n), .rstReq(rstReq), .instrDone(instrDone),
    .retiDone(retiDone), .gieSet(gieSet), .gieClr(gieClr), .irqIn(irqIn),
    .srcEnable(srcEnable), .vecLoad(vl1), .pcPush(pp1), .vecAddr(va1),
    .gieState(g1));

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expects an interrupt entry for source index src on both variants
  task automatic expectEntry(string req, int src);
    check(req, {vl0, pp0, vl1, pp1}, 4'b1111);
    check(req, int'(va0), src + 1);
    check(req, int'(va1), 2 * (src + 1));
  endtask

  task automatic expectIdle(string req);
    check(req, {vl0, pp0, vl1, pp1}, 4'b0000);
  endtask

  task automatic flushAll;
    rstReq = 1; tick; rstReq = 0; tick;
  endtask

  task automatic doReti;
    retiDone = 1; tick; retiDone = 0;
  endtask

  task automatic enableGie;
    gieSet = 1; tick; gieSet = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tick; tick;
    check("R1", {vl0, pp0, g0}, 0);
    rst_n = 1; tick;
    check("R1", {vl0, pp0, g0, vl1, pp1, g1}, 0);

    // R9 flag set/clear
    enableGie;
    check("R9", g0, 1);
    gieClr = 1; tick; gieClr = 0;
    check("R9", g0, 0);

    // R2/R3/R4/R6/R7 sweep over every ordered pair of sources
    for (int i = 0; i < N; i++) begin
      for (int j = i; j < N; j++) begin
        flushAll;
        enableGie;
        irqIn = N'(1) << i | N'(1) << j; tick; irqIn = '0;
        tick;
        expectEntry("R3", i);                 // lower index first (R2 address)
        tick;
        expectIdle("R4");                     // strobe lasts one cycle
        check("R4", {g0, g1}, 0);             // flag dropped on entry
        doReti;
        check("R6", {g0, g1}, 2'b11);
        tick;
        expectIdle("R6");                     // hold-off cycle
        tick;
        if (j != i) begin
          expectEntry("R3", j);               // loser served after return
          tick; doReti; tick; tick;
        end
        expectIdle("R7");                     // single source served once
      end
    end

    // R5 disabled source waits
    flushAll;
    srcEnable = ~(N'(1) << 3);
    enableGie;
    irqIn = N'(1) << 3; tick; irqIn = '0;
    tick; expectIdle("R5");
    tick; expectIdle("R5");
    srcEnable = '1; tick;
    expectEntry("R5", 3);
    tick; doReti; tick; tick;

    // R10 no acceptance without an instruction boundary
    flushAll;
    instrDone = 0;
    enableGie;
    irqIn = N'(1) << 5; tick; irqIn = '0;
    tick; expectIdle("R10");
    tick; expectIdle("R10");
    instrDone = 1; tick;
    expectEntry("R10", 5);
    tick; doReti; tick; tick;

    // R7 repeated events merge; global flag off until set
    flushAll;
    irqIn = N'(1) << 2; tick; irqIn = '0; tick;
    irqIn = N'(1) << 2; tick; irqIn = '0;
    expectIdle("R7");
    enableGie;
    tick;
    expectEntry("R7", 2);
    tick; doReti; tick; tick; tick;
    expectIdle("R7");

    // R8 reset request overrides pending work
    doReti;
    irqIn = N'(1) << 0; tick;
    irqIn = N'(1) << 1; rstReq = 1; tick; rstReq = 0; irqIn = '0;
    check("R8", {vl0, pp0, vl1, pp1}, 4'b1010);
    check("R8", int'(va0), 0);
    check("R8", int'(va1), 0);
    check("R8", {g0, g1}, 0);
    enableGie; tick; tick;
    expectIdle("R8");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule